// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight hardware lock tokens that two independent agents, a left port and a right port, use to coordinate access to shared resources. Each port has its own select, write strobe, 3-bit index and 8-bit data lines. A port reaches the bank only while its memory enable is inactive and its semaphore select is active. A port asks for a token by writing 0 on data bit 0 and gives it back by writing 1. A read shows the port's own view of the chosen token: 0 means "mine" and 1 means "not mine". That view is copied onto all eight data bits.

Each token also remembers a pending request from each side. When one port asks for a token that the other port holds, the request waits. When the holder releases the token, it goes straight to the waiting port, with no time in which the token is free. When both ports ask for a free token in the same cycle, the left port gets it and the right request waits.

Writes take effect on the rising clock edge. Read data is combinational from the registered token state, so a read in the cycle after a write shows the result of that write.

Top module: `sem_bank`

## Requirements
- R1: After reset all eight tokens are free, and a read of any index from either port returns 8'hFF.
- R2: A port accesses the bank only when its `*_mem_ce_n` is 1 and its `*_sem_n` is 0. Otherwise its write changes no token and its `*_rdata` is 8'h00.
- R3: Only data bit 0 of a write matters. A read returns 8'h00 when the reading port holds the indexed token, and 8'hFF otherwise.
- R4: A write of 0 to a free token gives the token to the writing port. From the next cycle that port reads 8'h00 and the other port reads 8'hFF.
- R5: A write of 0 to a token held by the other port changes nothing visible: the requester keeps reading 8'hFF and the holder keeps reading 8'h00. The request is remembered.
- R6: When the holder writes 1 while the other port has a remembered request, the token passes directly to the other port. The new holder reads 8'h00, the former holder reads 8'hFF, and the request is used up.
- R7: When the holder writes 1 and no request from the other port is waiting, the token becomes free.
- R8: A write of 0 by the current holder has no effect.
- R9: When both ports write 0 in the same cycle to a free token, the left port gets it and the right port's request is remembered.
- R10: A write of 1 by a port that does not hold the token cancels that port's remembered request.
- R11: The 3-bit index selects one of eight tokens. An access to one token never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_mem_ce_n | input | 1 | Left memory enable, active low. It must be 1 for a token access |
| l_sem_n | input | 1 | Left token select, active low |
| l_we | input | 1 | Left write strobe, active high |
| l_addr | input | 3 | Left token index |
| l_wdata | input | 8 | Left write data. Only bit 0 is used |
| l_rdata | output | 8 | Left read view, replicated on all bits |
| r_mem_ce_n | input | 1 | Right memory enable, active low. It must be 1 for a token access |
| r_sem_n | input | 1 | Right token select, active low |
| r_we | input | 1 | Right write strobe, active high |
| r_addr | input | 3 | Right token index |
| r_wdata | input | 8 | Right write data. Only bit 0 is used |
| r_rdata | output | 8 | Right read view, replicated on all bits |

## Verification
A wrong holder field appears at the ports in the same cycle that either port reads that index. A lost or stale pending request stays hidden until the holder releases: the token then goes free, or to the wrong port, one cycle after the releasing write. For this reason the bench runs many request, release and withdraw sequences on shared indexes. It compares both read ports against a behavioural model on every clock, so a divergence is reported within one cycle of the first read that can show it.

// File: rtl/sem_pkg.sv
package sem_pkg;
    localparam int NUM_SEM = 8;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(NUM_SEM);

    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_LEFT  = 2'd1,
        HOLD_RIGHT = 2'd2
    } holder_e;

    typedef struct packed {
        holder_e holder;
        logic    wait_l;
        logic    wait_r;
    } sem_st_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               mem_ce_n,
    input  logic               sem_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic               acc,
    output logic [NUM_SEM-1:0] wr_vec,
    output logic               wbit,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        acc    = mem_ce_n && !sem_n;
        wbit   = wdata[0];
        wr_vec = '0;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (acc && we && (addr == IDX_W'(i))) wr_vec[i] = 1'b1;
        end
        rdata = acc ? {DATA_W{!own_vec[addr]}} : '0;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wl,
    input  logic vl,
    input  logic wr,
    input  logic vr,
    output logic own_l,
    output logic own_r
);
    sem_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.holder)
            HOLD_NONE: begin
                if (wl && !vl) begin
                    st_d.holder = HOLD_LEFT;
                    st_d.wait_r = wr && !vr;
                end else if (wr && !vr) begin
                    st_d.holder = HOLD_RIGHT;
                end
            end
            HOLD_LEFT: begin
                if (wr) st_d.wait_r = !vr;
                if (wl && vl) begin
                    if (st_d.wait_r) begin
                        st_d.holder = HOLD_RIGHT;
                        st_d.wait_r = 1'b0;
                    end else begin
                        st_d.holder = HOLD_NONE;
                    end
                end
            end
            HOLD_RIGHT: begin
                if (wl) st_d.wait_l = !vl;
                if (wr && vr) begin
                    if (st_d.wait_l) begin
                        st_d.holder = HOLD_LEFT;
                        st_d.wait_l = 1'b0;
                    end else begin
                        st_d.holder = HOLD_NONE;
                    end
                end
            end
            default: st_d = '{HOLD_NONE, 1'b0, 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{HOLD_NONE, 1'b0, 1'b0};
        else        st_q <= st_d;
    end

    assign own_l = (st_q.holder == HOLD_LEFT);
    assign own_r = (st_q.holder == HOLD_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_mem_ce_n,
    input  logic              l_sem_n,
    input  logic              l_we,
    input  logic [IDX_W-1:0]  l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_mem_ce_n,
    input  logic              r_sem_n,
    input  logic              r_we,
    input  logic [IDX_W-1:0]  r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic               l_acc, r_acc, l_wbit, r_wbit;
    logic [NUM_SEM-1:0] l_wr, r_wr, own_l, own_r;

    sem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_ldec (
        .mem_ce_n(l_mem_ce_n), .sem_n(l_sem_n), .we(l_we), .addr(l_addr),
        .wdata(l_wdata), .own_vec(own_l), .acc(l_acc), .wr_vec(l_wr),
        .wbit(l_wbit), .rdata(l_rdata)
    );

    sem_port_dec #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rdec (
        .mem_ce_n(r_mem_ce_n), .sem_n(r_sem_n), .we(r_we), .addr(r_addr),
        .wdata(r_wdata), .own_vec(own_r), .acc(r_acc), .wr_vec(r_wr),
        .wbit(r_wbit), .rdata(r_rdata)
    );

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .wl(l_wr[g]), .vl(l_wbit), .wr(r_wr[g]), .vr(r_wbit),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
    import sem_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               l_acc,
    input logic               l_we,
    input logic               l_wbit,
    input logic [IDX_W-1:0]   l_addr,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_acc,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r
);
    AST_RDATA_REPL: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1)); // R3

    AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_acc && !r_acc) |=> ($stable(own_l) && $stable(own_r))); // R2

    AST_FREE_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && l_we && !l_wbit && !own_l[l_addr] && !own_r[l_addr])
        |=> own_l[$past(l_addr)]); // R4

    AST_HOLDER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (l_acc && l_we && !l_wbit && own_l[l_addr]) |=> own_l[$past(l_addr)]); // R8
endmodule

bind sem_bank sem_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_acc(l_acc), .l_we(l_we), .l_wbit(l_wbit), .l_addr(l_addr), .l_rdata(l_rdata),
    .r_acc(r_acc), .r_rdata(r_rdata), .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_mem_ce_n = 1'b1, l_sem_n = 1'b1, l_we = 1'b0;
    logic [2:0] l_addr = '0;
    logic [7:0] l_wdata = '0, l_rdata;
    logic       r_mem_ce_n = 1'b1, r_sem_n = 1'b1, r_we = 1'b0;
    logic [2:0] r_addr = '0;
    logic [7:0] r_wdata = '0, r_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    int hold [8];
    bit pend_l [8];
    bit pend_r [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank u_sem_bank (.*);

    function automatic logic [7:0] view(input bit acc, input int idx, input int side);
        if (!acc) return 8'h00;
        return (hold[idx] == side) ? 8'h00 : 8'hFF;
    endfunction

    // Reference update: hold 0 free, 1 left, 2 right
    task automatic model_step();
        bit la = l_mem_ce_n && !l_sem_n;
        bit ra = r_mem_ce_n && !r_sem_n;
        for (int i = 0; i < 8; i++) begin
            bit lw = la && l_we && (int'(l_addr) == i);
            bit rw = ra && r_we && (int'(r_addr) == i);
            bit lreq = lw && !l_wdata[0];
            bit lrel = lw && l_wdata[0];
            bit rreq = rw && !r_wdata[0];
            bit rrel = rw && r_wdata[0];
            if (hold[i] == 0) begin
                if (lreq) begin hold[i] = 1; pend_r[i] = rreq; end
                else if (rreq) hold[i] = 2;
            end else if (hold[i] == 1) begin
                if (rw) pend_r[i] = rreq;
                if (lrel) begin
                    if (pend_r[i]) begin hold[i] = 2; pend_r[i] = 0; end
                    else hold[i] = 0;
                end
            end else begin
                if (lw) pend_l[i] = lreq;
                if (rrel) begin
                    if (pend_l[i]) begin hold[i] = 1; pend_l[i] = 0; end
                    else hold[i] = 0;
                end
            end
        end
    endtask

    task automatic cyc(input string tag);
        logic [7:0] el, er;
        #1;
        el = view(l_mem_ce_n && !l_sem_n, int'(l_addr), 1);
        er = view(r_mem_ce_n && !r_sem_n, int'(r_addr), 2);
        total += 2;
        if (l_rdata !== el) begin
            bad++;
            $display("FAIL %s left rdata actual=%h expected=%h", tag, l_rdata, el);
        end
        if (r_rdata !== er) begin
            bad++;
            $display("FAIL %s right rdata actual=%h expected=%h", tag, r_rdata, er);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic set_l(input bit en, input bit we, input int a, input logic [7:0] d);
        l_mem_ce_n = 1'b1; l_sem_n = !en; l_we = we; l_addr = 3'(a); l_wdata = d;
    endtask
    task automatic set_r(input bit en, input bit we, input int a, input logic [7:0] d);
        r_mem_ce_n = 1'b1; r_sem_n = !en; r_we = we; r_addr = 3'(a); r_wdata = d;
    endtask
    task automatic rd_both(input int a, input string tag);
        set_l(1, 0, a, 0); set_r(1, 0, a, 0); cyc(tag);
    endtask
    task automatic idle();
        set_l(0, 0, 0, 0); set_r(0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin hold[i] = 0; pend_l[i] = 0; pend_r[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 8; a++) rd_both(a, "R1");
        // R4: grant on free
        idle(); set_l(1, 1, 2, 8'h00); cyc("R4");
        rd_both(2, "R4");
        // R5: request while held
        idle(); set_r(1, 1, 2, 8'h00); cyc("R5");
        rd_both(2, "R5");
        // R6: handoff
        idle(); set_l(1, 1, 2, 8'h01); cyc("R6");
        rd_both(2, "R6");
        // R8: holder writes 0 again
        idle(); set_r(1, 1, 2, 8'h00); cyc("R8");
        rd_both(2, "R8");
        // R7: release with no pending
        idle(); set_r(1, 1, 2, 8'hFF); cyc("R7");
        rd_both(2, "R7");
        // R9: simultaneous request, left wins then hands off
        set_l(1, 1, 5, 8'h00); set_r(1, 1, 5, 8'h00); cyc("R9");
        rd_both(5, "R9");
        idle(); set_l(1, 1, 5, 8'h01); cyc("R9");
        rd_both(5, "R9");
        // R10: left requests then withdraws, right releases -> free
        idle(); set_l(1, 1, 5, 8'h00); cyc("R10");
        set_l(1, 1, 5, 8'h01); cyc("R10");
        idle(); set_r(1, 1, 5, 8'h01); cyc("R10");
        rd_both(5, "R10");
        // R3: only bit 0 matters
        idle(); set_l(1, 1, 6, 8'hFE); cyc("R3");
        rd_both(6, "R3");
        idle(); set_l(1, 1, 6, 8'h01); cyc("R3");
        rd_both(6, "R3");
        // R2: blocked accesses
        idle(); l_mem_ce_n = 1'b0; l_sem_n = 1'b0; l_we = 1'b1; l_addr = 3'd7; l_wdata = 8'h00;
        cyc("R2");
        idle(); r_mem_ce_n = 1'b1; r_sem_n = 1'b1; r_we = 1'b1; r_addr = 3'd7; r_wdata = 8'h00;
        cyc("R2");
        rd_both(7, "R2");
        // R11: random traffic over all indexes
        for (int n = 0; n < 3000; n++) begin
            l_mem_ce_n = ($urandom_range(0, 9) != 0);
            l_sem_n    = ($urandom_range(0, 9) == 0);
            l_we       = $urandom_range(0, 1);
            l_addr     = 3'($urandom_range(0, 7));
            l_wdata    = 8'($urandom);
            r_mem_ce_n = ($urandom_range(0, 9) != 0);
            r_sem_n    = ($urandom_range(0, 9) == 0);
            r_we       = $urandom_range(0, 1);
            r_addr     = ($urandom_range(0, 1) != 0) ? l_addr : 3'($urandom_range(0, 7));
            r_wdata    = 8'($urandom);
            cyc("R11");
        end
        for (int a = 0; a < 8; a++) rd_both(a, "R11");
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule